// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a 16x16 multiplier that a processor reaches through a small single-cycle register bus. Software writes the first operand to one of four addresses. The address it uses selects the arithmetic mode: unsigned product, signed product, unsigned accumulate or signed accumulate. Writing the second operand starts one computation. The 32-bit answer appears one clock later in a low-half and a high-half result register. A read-only extension register carries sign or carry information, and its meaning depends on the mode.

Both result halves can be written by software. In the accumulate modes this preloads the running sum. Every readable register can be reached with word or byte accesses. A byte access touches only the low byte of a register.

Top module: `mulacc_unit`

## Requirements
- R1: After reset every register reads 0x0000, and the mode is unsigned product, so an operand-2 write before any operand-1 write overwrites the preloaded result instead of adding to it.
- R2: Register index encoding on busAddr: 0 = operand 1 with unsigned product, 1 = operand 1 with signed product, 2 = operand 1 with unsigned accumulate, 3 = operand 1 with signed accumulate, 4 = operand 2, 5 = result low, 6 = result high, 7 = extension. A write to indices 0..3 stores operand 1 and latches the mode. Reading any of indices 0..3 returns the one stored operand 1.
- R3: Operand 2 reads back the last value written to it. A word or byte write to it starts one computation, and the result and extension registers show the outcome in the cycle after the write.
- R4: Unsigned product mode: the result is op1*op2 taken as unsigned numbers, and the extension reads 0x0000.
- R5: Signed product mode: the result is the two's-complement product, and the extension reads 0xFFFF if that product is negative and 0x0000 otherwise.
- R6: Unsigned accumulate mode: the result is {high,low} + op1*op2 modulo 2^32, and the extension reads 0x0001 when this addition carries out of bit 31 and 0x0000 otherwise.
- R7: Signed accumulate mode: the result is {high,low} plus the signed product, modulo 2^32, and the extension reads 0xFFFF when bit 31 of the new result is set and 0x0000 otherwise.
- R8: Result low and result high are writable and read back the written value.
- R9: Writes to the extension register are ignored. It changes only when a computation completes.
- R10: When wrByte is high and wrWord low, the write replaces bits 7:0 only and keeps bits 15:8. When rdByte is high, a read returns bits 7:0 zero-extended to 16 bits.
- R11: If a computation completes in the same cycle as a software write to a result half, the computed value is stored.
- R12: busRdata is 0x0000 whenever rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register index |
| busWdata | input | DATA_W | Write data |
| wrWord | input | 1 | Word write strobe |
| wrByte | input | 1 | Low-byte write strobe |
| rdEn | input | 1 | Read enable |
| rdByte | input | 1 | Byte-wide read when high |
| busRdata | output | DATA_W | Read data, combinational |

## Verification
If the latched mode is wrong, the next computation stores the wrong result. The fault shows on the result and extension reads one cycle after the operand-2 write. The accumulate modes depend on the old result, so a bad preload or a lost computation spreads into every later sum. The sweep therefore reads all three outputs after each operation, covering every mode crossed with sign-boundary operand values. A wrong operand register or bad byte merging shows up directly on the next read-back of that register.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mode_e;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_OP1_UMUL = 3'd0,
    IDX_OP1_SMUL = 3'd1,
    IDX_OP1_UMAC = 3'd2,
    IDX_OP1_SMAC = 3'd3,
    IDX_OP2      = 3'd4,
    IDX_RES_LO   = 3'd5,
    IDX_RES_HI   = 3'd6,
    IDX_EXT      = 3'd7
  } reg_idx_e;

  typedef struct packed {
    reg_idx_e idx;
    logic     ldOp1;
    logic     ldOp2;
    logic     ldLo;
    logic     ldHi;
    logic     byteWr;
    logic     compute;
    logic     rdValid;
    logic     rdByte;
  } dp_strobe_t;
endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrWord,
  input  logic              wrByte,
  input  logic              rdEn,
  input  logic              rdByte,
  output dp_strobe_t        strobe,
  output mode_e             mode
);
  localparam int IDX_W = REG_IDX_W;

  logic     inRange;
  logic     wrHit;
  logic     computeQ;
  reg_idx_e idx;

  assign inRange = (busAddr >> IDX_W) == '0;
  assign idx     = reg_idx_e'(busAddr[IDX_W-1:0]);
  assign wrHit   = (wrWord | wrByte) & inRange;

  always_comb begin
    strobe         = '0;
    strobe.idx     = idx;
    strobe.byteWr  = wrByte & ~wrWord;
    strobe.compute = computeQ;
    strobe.rdValid = rdEn & inRange;
    strobe.rdByte  = rdByte;
    case (idx)
      IDX_OP1_UMUL, IDX_OP1_SMUL,
      IDX_OP1_UMAC, IDX_OP1_SMAC: strobe.ldOp1 = wrHit;
      IDX_OP2:                    strobe.ldOp2 = wrHit;
      IDX_RES_LO:                 strobe.ldLo  = wrHit;
      IDX_RES_HI:                 strobe.ldHi  = wrHit;
      default:                    ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_UMUL;
      computeQ <= 1'b0;
    end else begin
      computeQ <= strobe.ldOp2;
      if (strobe.ldOp1) mode <= mode_e'(busAddr[1:0]);
    end
  end

  // R2: an operand-1 write leaves the mode equal to the low address bits used
  p_mode_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((wrWord || wrByte) && ((busAddr >> IDX_W) == '0) && !busAddr[2])
      |=> (mode == mode_e'($past(busAddr[1:0]))));
endmodule

// File: rtl/mulacc_dp.sv
module mulacc_dp
  import mulacc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  mode_e             mode,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] op1, op2, resLo, resHi, ext;
  logic [PROD_W-1:0] opAExt, opBExt, prod, acc, newRes;
  logic [PROD_W:0]   sum;
  logic [DATA_W-1:0] newExt, rv;
  logic              isSigned, isAcc;

  function automatic logic [DATA_W-1:0] mergeWr(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] nw,
                                                input logic              isByte);
    return isByte ? {old[DATA_W-1:BYTE_W], nw[BYTE_W-1:0]} : nw;
  endfunction

  assign isSigned = mode[0];
  assign isAcc    = mode[1];
  assign opAExt   = isSigned ? {{DATA_W{op1[DATA_W-1]}}, op1} : {{DATA_W{1'b0}}, op1};
  assign opBExt   = isSigned ? {{DATA_W{op2[DATA_W-1]}}, op2} : {{DATA_W{1'b0}}, op2};
  assign prod     = opAExt * opBExt;
  assign acc      = {resHi, resLo};
  assign sum      = {1'b0, acc} + {1'b0, prod};
  assign newRes   = isAcc ? sum[PROD_W-1:0] : prod;

  always_comb begin
    case (mode)
      MODE_UMUL: newExt = '0;
      MODE_SMUL: newExt = {DATA_W{prod[PROD_W-1]}};
      MODE_UMAC: newExt = DATA_W'(sum[PROD_W]);
      default:   newExt = {DATA_W{sum[PROD_W-1]}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1   <= '0;
      op2   <= '0;
      resLo <= '0;
      resHi <= '0;
      ext   <= '0;
    end else begin
      if (strobe.ldOp1) op1 <= mergeWr(op1, busWdata, strobe.byteWr);
      if (strobe.ldOp2) op2 <= mergeWr(op2, busWdata, strobe.byteWr);
      if (strobe.compute) begin
        {resHi, resLo} <= newRes;
        ext            <= newExt;
      end else begin
        if (strobe.ldLo) resLo <= mergeWr(resLo, busWdata, strobe.byteWr);
        if (strobe.ldHi) resHi <= mergeWr(resHi, busWdata, strobe.byteWr);
      end
    end
  end

  always_comb begin
    case (strobe.idx)
      IDX_OP2:    rv = op2;
      IDX_RES_LO: rv = resLo;
      IDX_RES_HI: rv = resHi;
      IDX_EXT:    rv = ext;
      default:    rv = op1;
    endcase
    if (!strobe.rdValid)    rdData = '0;
    else if (strobe.rdByte) rdData = {{(DATA_W-BYTE_W){1'b0}}, rv[BYTE_W-1:0]};
    else                    rdData = rv;
  end

  // R4: the unsigned product never leaves a nonzero extension
  p_umul_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compute && mode == MODE_UMUL) |=> (ext == '0));
  // R5: the signed product extension is all-ones or zero and agrees with the result sign
  p_smul_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compute && mode == MODE_SMUL)
      |=> ((ext == '0 || ext == '1) && (ext[0] == resHi[DATA_W-1])));
  // R6: the unsigned accumulate extension is a single carry bit
  p_umac_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compute && mode == MODE_UMAC) |=> (ext[DATA_W-1:1] == '0));
  // R7: the signed accumulate extension mirrors bit 31 of the new result
  p_smac_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compute && mode == MODE_SMAC)
      |=> ((ext == '0 || ext == '1) && (ext[0] == resHi[DATA_W-1])));
  // R9: the extension holds unless a computation completes
  p_ext_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.compute |=> $stable(ext));
endmodule

// File: rtl/mulacc_unit.sv
module mulacc_unit
  import mulacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              wrWord,
  input  logic              wrByte,
  input  logic              rdEn,
  input  logic              rdByte,
  output logic [DATA_W-1:0] busRdata
);
  dp_strobe_t strobe;
  mode_e      mode;

  mulacc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrWord(wrWord), .wrByte(wrByte),
    .rdEn(rdEn), .rdByte(rdByte), .strobe(strobe), .mode(mode)
  );

  mulacc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .busWdata(busWdata), .rdData(busRdata)
  );

  // R12: an idle bus reads zero
  p_idle_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (busRdata == '0));
  // R10: byte reads zero-extend
  p_byte_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdByte) |-> (busRdata[DATA_W-1:8] == '0));
endmodule

// File: tb/mulacc_unit_tb.sv
module mulacc_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        wrWord = 1'b0, wrByte = 1'b0, rdEn = 1'b0, rdByte = 1'b0;
  logic [15:0] busRdata;
  int          nTests = 0, nFails = 0;

  localparam logic [2:0] OP2 = 3'd4, LO = 3'd5, HI = 3'd6, EXT = 3'd7;
  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hABCD, 16'h00FF};
  string       modeTag [4] = '{"R4", "R5", "R6", "R7"};

  mulacc_unit u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .wrWord(wrWord), .wrByte(wrByte), .rdEn(rdEn), .rdByte(rdByte), .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nTests++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] d, input logic isByte);
    busAddr = idx; busWdata = d; wrWord = ~isByte; wrByte = isByte;
    @(negedge clk);
    wrWord = 1'b0; wrByte = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, input logic isByte, output logic [15:0] v);
    busAddr = idx; rdEn = 1'b1; rdByte = isByte;
    #1 v = busRdata;
    rdEn = 1'b0; rdByte = 1'b0;
  endtask

  task automatic model(input int m, input logic [15:0] a, input logic [15:0] b,
                       input logic [31:0] acc, output logic [31:0] r, output logic [15:0] e);
    longint p, s;
    if (m % 2 == 1) p = longint'($signed(a)) * longint'($signed(b));
    else            p = longint'(a) * longint'(b);
    if (m < 2) begin
      r = p[31:0];
      e = (m == 1 && p < 0) ? 16'hFFFF : 16'h0000;
    end else begin
      s = longint'(acc) + longint'(p[31:0]);
      r = s[31:0];
      if (m == 2) e = {15'b0, s[32]};
      else        e = r[31] ? 16'hFFFF : 16'h0000;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    logic [15:0] v, e;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: all registers zero after reset
    for (int k = 0; k < 8; k++) begin
      rd(3'(k), 1'b0, v);
      chk("R1 reset value", v, 16'h0000);
    end
    // R1: default mode is unsigned product (preload discarded)
    wr(LO, 16'h0005, 1'b0);
    wr(OP2, 16'h0003, 1'b0);
    @(negedge clk);
    rd(LO, 1'b0, v); chk("R1 default mode lo", v, 16'h0000);

    // R12: idle bus reads zero
    wr(3'd0, 16'h5A5A, 1'b0);
    busAddr = 3'd0; #1 chk("R12 idle read", busRdata, 16'h0000);

    // R8: result halves writable
    wr(LO, 16'hC0DE, 1'b0); wr(HI, 16'hFACE, 1'b0);
    rd(LO, 1'b0, v); chk("R8 lo readback", v, 16'hC0DE);
    rd(HI, 1'b0, v); chk("R8 hi readback", v, 16'hFACE);

    // R10: byte write / byte read
    wr(LO, 16'h9977, 1'b1);
    rd(LO, 1'b0, v); chk("R10 lo byte merge", v, 16'hC077);
    wr(3'd0, 16'hBEEF, 1'b0);
    wr(3'd0, 16'h1234, 1'b1);
    rd(3'd3, 1'b0, v); chk("R10 op1 byte merge via idx3 (R2)", v, 16'hBE34);
    rd(3'd0, 1'b1, v); chk("R10 byte read", v, 16'h0034);

    // R3: byte write to operand 2 starts a computation
    wr(OP2, 16'h1100, 1'b0);
    wr(OP2, 16'hAB03, 1'b1);
    rd(OP2, 1'b0, v); chk("R3 op2 readback", v, 16'h1103);
    @(negedge clk);
    model(0, 16'hBE34, 16'h1103, 32'h0, r, e);
    rd(LO, 1'b0, v); chk("R3 byte-started lo", v, r[15:0]);
    rd(HI, 1'b0, v); chk("R3 byte-started hi", v, r[31:16]);

    // R9: extension write ignored
    wr(EXT, 16'hFFFF, 1'b0);
    rd(EXT, 1'b0, v); chk("R9 ext write ignored", v, 16'h0000);
    rd(LO, 1'b0, v); chk("R9 lo untouched", v, r[15:0]);

    // R11: computation beats a simultaneous result write
    wr(3'd0, 16'h0003, 1'b0);
    wr(OP2, 16'h0005, 1'b0);
    wr(LO, 16'hAAAA, 1'b0);
    rd(LO, 1'b0, v); chk("R11 compute wins", v, 16'h000F);

    // R2..R7: sweep all modes over sign-boundary operands
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [31:0] pre;
          pre = {vals[(j + 5 * i + m) % 8], vals[(i + 3 * j) % 8]};
          wr(LO, pre[15:0], 1'b0);
          wr(HI, pre[31:16], 1'b0);
          wr(3'(m), vals[i], 1'b0);
          wr(OP2, vals[j], 1'b0);
          @(negedge clk);
          model(m, vals[i], vals[j], pre, r, e);
          rd(LO, 1'b0, v);  chk({modeTag[m], " result lo"}, v, r[15:0]);
          rd(HI, 1'b0, v);  chk({modeTag[m], " result hi"}, v, r[31:16]);
          rd(EXT, 1'b0, v); chk({modeTag[m], " extension"}, v, e);
          if (j == 0) begin
            rd(3'((m + 1) % 4), 1'b0, v); chk("R2 op1 alias", v, vals[i]);
          end
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule